// File: doc/BRIEF.md
# Register-File Execution Stage with Sign Flags

This block is the execute stage of a small 16-bit word-addressed processor. It holds eight general registers, an arithmetic/logic unit with three operations (add, bitwise and, bitwise invert) and a sign-flag register holding negative, zero and positive indications. The instruction word drives the decode directly. The operand fields pick the two registers that are read, the destination register, and whether the second operand comes from a register or from a small literal inside the instruction.

Load instructions do not compute a value. The word fetched from memory arrives on a separate data input and is written into the destination register when the load write-back strobe is high. The flags follow the instruction class. They change only when an operate or load instruction writes a register. Address computation, stores and control-flow instructions leave both the registers and the flags untouched.

Top module: `exec_core`

## Requirements
- R1: After reset, all eight registers read 0 and the flags are N=0, Z=1, P=0.
- R2: Opcode 0001 (bits [15:12]) with bit 5 = 0 gives alu_out = reg[bits 8:6] + reg[bits 2:0], taken modulo 2^16. The result is written to reg[bits 11:9] at the next rising clock edge.
- R3: When bit 5 = 1 on an add or an and, the second operand is bits [4:0] sign-extended to 16 bits, in place of a register.
- R4: Opcode 0101 gives alu_out = reg[bits 8:6] AND the second operand. The result is written to the destination register.
- R5: Opcode 1001 gives alu_out = bitwise NOT of reg[bits 8:6] and writes it to the destination. Bits [5:0] have no effect on the result.
- R6: Exactly one flag is set at all times. A register write sets N when bit 15 of the written value is 1, Z when the value is 0, and P otherwise.
- R7: Opcodes 0110 (base+offset load) and 1010 (indirect load) write ld_data to the destination register and update the flags only when ld_wb = 1. With ld_wb = 0 they change nothing.
- R8: Every other opcode, for example 0000, 0010, 0011, 1100 and 1110, writes no register and leaves the flags unchanged, whatever the value of ld_wb.
- R9: rd_a shows reg[bits 8:6] and rd_b shows reg[bits 2:0] combinationally. alu_out is 0 for opcodes that are not operate opcodes.
- R10: Writes take effect at the clock edge. A source register that is also the destination reads its old value during the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr | input | 16 | Instruction word being executed |
| ld_data | input | 16 | Memory word for load write-back |
| ld_wb | input | 1 | Load write-back select |
| alu_out | output | 16 | Combinational ALU result |
| rd_a | output | 16 | Register read by field [8:6] |
| rd_b | output | 16 | Register read by field [2:0] |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |

## Verification
The assertions check four things on every cycle. The flags stay one-hot. Any register write leaves the flags matching the sign of the value written. A cycle with no write leaves the flags stable. The add and invert results agree with the register read ports. Other behaviours can only be shown by the bench's scenarios, because they depend on register contents built up over many instructions. These are the reset contents, literal sign extension at the field's extremes, the load strobe gating, read-before-write on a shared register, and the absence of writes from non-writing opcodes.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int DATA_W = 16;
  localparam int IMM_W  = 5;

  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_INV = 4'b1001;
  localparam logic [3:0] OPC_LDB = 4'b0110;
  localparam logic [3:0] OPC_LDI = 4'b1010;

  // widen the low literal field by copying its top bit
  function automatic logic [DATA_W-1:0] widen_lit(input logic [IMM_W-1:0] lit);
    return {{(DATA_W-IMM_W){lit[IMM_W-1]}}, lit};
  endfunction

  // operation on two words selected by opcode
  function automatic logic [DATA_W-1:0] alu_eval(input logic [3:0] opc,
                                                 input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    case (opc)
      OPC_ADD: return a + b;
      OPC_AND: return a & b;
      OPC_INV: return ~a;
      default: return '0;
    endcase
  endfunction

  // sign class of a word as {n,z,p}
  function automatic logic [2:0] sign_class(input logic [DATA_W-1:0] v);
    if (v[DATA_W-1])  return 3'b100;
    else if (v == '0) return 3'b010;
    else              return 3'b001;
  endfunction
endpackage

// File: rtl/op_decode.sv
module op_decode (
  input  logic [3:0] opc,
  input  logic       ld_wb,
  output logic       is_opr,
  output logic       is_ld,
  output logic       wr_en
);
  import exec_pkg::*;

  always_comb begin
    is_opr = (opc == OPC_ADD) || (opc == OPC_AND) || (opc == OPC_INV);
    is_ld  = (opc == OPC_LDB) || (opc == OPC_LDI);
    wr_en  = is_opr || (is_ld && ld_wb);
  end
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[g] <= '0;
      else if (we && (waddr == AW'(g)))
        q[g] <= wdata;
    end
  end

  assign rdata_a = q[raddr_a];
  assign rdata_b = q[raddr_b];
endmodule

// File: rtl/alu_unit.sv
module alu_unit #(
  parameter int DW = 16,
  parameter int IW = 5
) (
  input  logic [3:0]    opc,
  input  logic          lit_sel,
  input  logic [IW-1:0] lit,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  output logic [DW-1:0] result
);
  import exec_pkg::*;

  logic [DW-1:0] opnd_b;

  always_comb begin
    opnd_b = lit_sel ? {{(DW-IW){lit[IW-1]}}, lit} : src_b;
    result = alu_eval(opc, src_a, opnd_b);
  end
endmodule

// File: rtl/sign_flags.sv
module sign_flags #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [DW-1:0] val,
  output logic          n,
  output logic          z,
  output logic          p
);
  import exec_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      {n, z, p} <= 3'b010;
    else if (upd)
      {n, z, p} <= sign_class(val);
  end
endmodule

// File: rtl/exec_core.sv
module exec_core #(
  parameter int DW   = exec_pkg::DATA_W,
  parameter int NREG = 8,
  parameter int IW   = exec_pkg::IMM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   instr,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_wb,
  output logic [DW-1:0] alu_out,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_p
);
  localparam int AW = $clog2(NREG);

  logic [3:0]    opc;
  logic [AW-1:0] dst_f, s1_f, s2_f;
  logic          lit_sel;
  logic [IW-1:0] lit;
  logic          is_opr, is_ld, wr_en;
  logic [DW-1:0] wb_val;

  assign opc     = instr[15:12];
  assign dst_f   = instr[9 +: AW];
  assign s1_f    = instr[6 +: AW];
  assign s2_f    = instr[0 +: AW];
  assign lit_sel = instr[5];
  assign lit     = instr[IW-1:0];

  op_decode u_dec (
    .opc(opc), .ld_wb(ld_wb), .is_opr(is_opr), .is_ld(is_ld), .wr_en(wr_en)
  );

  reg_bank #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(dst_f), .wdata(wb_val),
    .raddr_a(s1_f), .raddr_b(s2_f), .rdata_a(rd_a), .rdata_b(rd_b)
  );

  alu_unit #(.DW(DW), .IW(IW)) u_alu (
    .opc(opc), .lit_sel(lit_sel), .lit(lit),
    .src_a(rd_a), .src_b(rd_b), .result(alu_out)
  );

  assign wb_val = is_ld ? ld_data : alu_out;

  sign_flags #(.DW(DW)) u_cc (
    .clk(clk), .rst_n(rst_n), .upd(wr_en), .val(wb_val),
    .n(flag_n), .z(flag_z), .p(flag_p)
  );

  logic unused_ok;
  assign unused_ok = is_opr ^ (^instr);
endmodule

// File: rtl/exec_core_chk.sv
module exec_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] instr,
  input logic [15:0] ld_data,
  input logic        ld_wb,
  input logic [15:0] alu_out,
  input logic [15:0] rd_a,
  input logic [15:0] rd_b,
  input logic        flag_n,
  input logic        flag_z,
  input logic        flag_p,
  input logic        wr_en,
  input logic [15:0] wb_val
);
  import exec_pkg::*;

  // R6
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_n, flag_z, flag_p}) == 1);

  // R6
  flags_follow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ({flag_n, flag_z, flag_p} == sign_class($past(wb_val))));

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({flag_n, flag_z, flag_p}));

  // R7
  load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((instr[15:12] == OPC_LDB || instr[15:12] == OPC_LDI) && ld_wb)
      |=> ({flag_n, flag_z, flag_p} == sign_class($past(ld_data))));

  // R2
  add_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[15:12] == OPC_ADD && !instr[5]) |-> (alu_out == 16'(rd_a + rd_b)));

  // R5
  invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[15:12] == OPC_INV) |-> (alu_out == ~rd_a));
endmodule

bind exec_core exec_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .ld_data(ld_data), .ld_wb(ld_wb),
  .alu_out(alu_out), .rd_a(rd_a), .rd_b(rd_b),
  .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p),
  .wr_en(wr_en), .wb_val(wb_val)
);

// File: tb/sim_exec_core.sv
`timescale 1ns/1ps
module sim_exec_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = 16'h0;
  logic [15:0] ld_data = 16'h0;
  logic        ld_wb = 1'b0;
  logic [15:0] alu_out, rd_a, rd_b;
  logic        flag_n, flag_z, flag_p;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] mreg [8];
  logic [2:0]  mflg;

  always #10 clk = ~clk;

  exec_core u0 (
    .clk(clk), .rst_n(rst_n), .instr(instr), .ld_data(ld_data), .ld_wb(ld_wb),
    .alu_out(alu_out), .rd_a(rd_a), .rd_b(rd_b),
    .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
  );

  task automatic cmp(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int opc, input int d, input int s1,
                                     input int low6);
    return 16'((opc << 12) | (d << 9) | (s1 << 6) | (low6 & 63));
  endfunction

  // one instruction: compare combinational outputs and prior flags, then advance model
  task automatic step(input string req, input logic [15:0] ins,
                      input logic [15:0] ldv, input logic wbs);
    int opc, a, b, lit, r;
    bit wr;
    logic [15:0] v;
    instr = ins; ld_data = ldv; ld_wb = wbs;
    #1;
    opc = int'(ins[15:12]);
    a = int'(mreg[ins[8:6]]);
    b = int'(mreg[ins[2:0]]);
    lit = int'(ins[4:0]);
    if (lit > 15) lit -= 32;
    if (ins[5]) b = lit & 65535;
    case (opc)
      1: r = (a + b) & 65535;
      5: r = a & b;
      9: r = a ^ 65535;
      default: r = 0;
    endcase
    cmp(req, "rd_a", rd_a, mreg[ins[8:6]]);
    cmp(req, "rd_b", rd_b, mreg[ins[2:0]]);
    cmp(req, "alu_out", alu_out, 16'(r));
    cmp(req, "flags", {13'd0, flag_n, flag_z, flag_p}, {13'd0, mflg});
    wr = (opc == 1 || opc == 5 || opc == 9) || ((opc == 6 || opc == 10) && wbs);
    v = (opc == 6 || opc == 10) ? ldv : 16'(r);
    @(posedge clk);
    @(negedge clk);
    if (wr) begin
      mreg[ins[11:9]] = v;
      mflg = v[15] ? 3'b100 : (v == 0 ? 3'b010 : 3'b001);
    end
  endtask

  task automatic readall(input string req);
    for (int k = 0; k < 8; k++) step(req, mk(0, 0, k, k), 16'h0, 1'b0);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) mreg[k] = 16'h0;
    mflg = 3'b010;
    repeat (2) @(negedge clk);
    cmp("R1", "flags in reset", {13'd0, flag_n, flag_z, flag_p}, 16'h2);
    rst_n = 1'b1;
    readall("R1");
    // literal adds: +5, -1, extremes +15 and -16
    step("R3", mk(1, 1, 0, 32 | 5), 16'h0, 1'b0);
    step("R3", mk(1, 2, 0, 32 | 31), 16'h0, 1'b0);
    step("R3", mk(1, 3, 0, 32 | 15), 16'h0, 1'b0);
    step("R3", mk(1, 4, 0, 32 | 16), 16'h0, 1'b0);
    // register adds, incl. carry out of bit 15
    step("R2", mk(1, 5, 1, 2), 16'h0, 1'b0);
    step("R2", mk(1, 6, 2, 2), 16'h0, 1'b0);
    step("R2", mk(1, 7, 1, 4), 16'h0, 1'b0);
    // loads with and without strobe
    step("R7", mk(6, 5, 0, 0), 16'h7FFF, 1'b1);
    step("R7", mk(10, 6, 0, 0), 16'h0000, 1'b1);
    step("R7", mk(10, 7, 0, 0), 16'h1234, 1'b0);
    step("R7", mk(6, 7, 0, 0), 16'hABCD, 1'b0);
    step("R7", mk(6, 0, 0, 0), 16'h8001, 1'b1);
    // positive overflow into negative
    step("R2", mk(1, 1, 5, 32 | 1), 16'h0, 1'b0);
    // and: register and literal
    step("R4", mk(5, 2, 5, 4), 16'h0, 1'b0);
    step("R4", mk(5, 3, 5, 32 | 0), 16'h0, 1'b0);
    step("R4", mk(5, 4, 2, 32 | 16), 16'h0, 1'b0);
    // invert, low bits all ones and otherwise
    step("R5", mk(9, 3, 5, 63), 16'h0, 1'b0);
    step("R5", mk(9, 4, 5, 0), 16'h0, 1'b0);
    step("R5", mk(9, 6, 0, 21), 16'h0, 1'b0);
    // non-writing opcodes, strobe high
    step("R8", mk(0, 1, 2, 3), 16'h0, 1'b1);
    step("R8", mk(2, 1, 2, 3), 16'hFFFF, 1'b1);
    step("R8", mk(3, 2, 2, 3), 16'h0, 1'b1);
    step("R8", mk(12, 3, 2, 3), 16'h0, 1'b1);
    step("R8", mk(14, 4, 2, 3), 16'h0, 1'b1);
    step("R8", mk(15, 5, 2, 3), 16'h0, 1'b1);
    readall("R8");
    // same register as source and destination
    step("R10", mk(1, 3, 3, 32 | 1), 16'h0, 1'b0);
    step("R10", mk(1, 3, 3, 3), 16'h0, 1'b0);
    step("R10", mk(9, 3, 3, 63), 16'h0, 1'b0);
    readall("R9");
    // mixed pattern sweep
    begin
      logic [15:0] lf = 16'hACE1;
      int ops [5] = '{1, 5, 9, 6, 10};
      for (int i = 0; i < 300; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step("R6", {4'(ops[i % 5]), lf[11:0]}, {lf[7:0], lf[15:8]}, lf[3]);
      end
    end
    readall("R6");
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule